// File: doc/BRIEF.md
# Vector Register Byte-Serial Store Unit

This block executes one unpredicated store of a whole vector register. The caller presents a 32-bit instruction word with a start strobe while the unit is idle. The unit decodes the word and selects the source vector register and the base register through two combinational read ports. When the base field holds 31, it takes the stack pointer from a dedicated input instead of the register file. It then forms the start address by adding the signed 9-bit immediate, scaled by the run-time vector length in bytes, to the 64-bit base.

If the word is not this store, or the feature is switched off, the unit reports an undefined instruction. A misaligned base raises an alignment fault when the general alignment check is enforced, or when the stack-pointer check is enabled and the base is the stack pointer. Both of these outcomes write nothing. Otherwise the unit captures the vector and sends it out as single-byte writes, one per accepted handshake, lowest byte first and at consecutive addresses.

Each write carries a tag-check flag and an aligned flag. The unit pulses `done` once when the operation ends, and `busy` covers the whole operation.

Top module: `vst_byte_store`

## Requirements
- R1: An instruction is accepted only when bits 31:22 equal 1110010110 and bits 15:13 equal 010, and `feat_en` is 1. Any other word, or `feat_en` at 0, ends with `done` and `undef` both high and no memory write.
- R2: While `start` is presented, `vreg_idx` shows instruction bits 4:0 and `gpr_idx` shows instruction bits 9:5.
- R3: The start address is base + sext(imm) * (vl_bits/8), taken modulo 2^64. The signed immediate imm is {instr[21:16], instr[12:10]} and ranges from -256 to 255.
- R4: A base field of 31 takes `sp_val` as the base and clears `mem_tagchk` on every write. Any other value takes `gpr_data` and sets `mem_tagchk`.
- R5: A store makes exactly vl_bits/8 writes. Write e carries vector bits [8e+7:8e] and goes to start address + e.
- R6: When `align_enf` is 1 and base[3:0] is not 0, the operation ends with `done` and `align_fault` high. `fault_addr` then equals the start address and no byte is written.
- R7: When the base field is 31, `sp_chk` is 1 and sp_val[3:0] is not 0, the unit faults as in R6 even if `align_enf` is 0.
- R8: On writes that do go out, `mem_aligned` equals (base[3:0] == 0).
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values.
- R10: `done` is a one-cycle pulse. It comes one cycle after the last handshake, or one cycle after acceptance for an undefined or faulting word. `busy` is high from acceptance through the `done` cycle, and `start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction strobe, taken only while idle |
| instr | input | 32 | Instruction word |
| feat_en | input | 1 | Vector feature enabled |
| align_enf | input | 1 | General 16-byte base alignment check enforced |
| sp_chk | input | 1 | Stack-pointer alignment check enabled |
| vl_bits | input | 12 | Current vector length in bits (multiple of 128, 128..MAX_VL) |
| gpr_idx | output | 5 | General register read index |
| gpr_data | input | 64 | General register read data |
| sp_val | input | 64 | Stack pointer value |
| vreg_idx | output | 5 | Vector register read index |
| vreg_data | input | 2048 | Vector register read data |
| mem_valid | output | 1 | Byte write request |
| mem_ready | input | 1 | Memory accepts the byte |
| mem_addr | output | 64 | Byte address |
| mem_data | output | 8 | Byte value |
| mem_tagchk | output | 1 | Access tag check requested |
| mem_aligned | output | 1 | Base was 16-byte aligned |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (one cycle) |
| undef | output | 1 | Undefined instruction, valid with done |
| align_fault | output | 1 | Alignment fault, valid with done |
| fault_addr | output | 64 | Start address of the faulting store |

## Verification
The hardest situation to reach is a second `start` that arrives in the middle of a long stream while the memory is stalling. If the unit wrongly accepted it, the byte sequence would be corrupted without any obvious symptom. The bench pulses `start` with an unrelated word three cycles into many stores, and throttles `mem_ready` at random throughout, so that stalls overlap the pulse. It then compares the full byte stream against the expected one. Address wrap-around at 2^64, both extremes of the immediate, and the stack-pointer fault with the general check disabled are reached with directed words and chosen register values.

// File: rtl/vst_pkg.sv
package vst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_FIN  = 2'd2
    } vst_state_e;

    typedef struct packed {
        vst_state_e  st;
        logic [63:0] addr;
        logic [63:0] faddr;
        logic        tag;
        logic        algn;
        logic        undef;
        logic        flt;
    } vst_ctl_t;

    localparam logic [9:0] OPC_HI = 10'b1110010110;
    localparam logic [2:0] OPC_MID = 3'b010;
endpackage

// File: rtl/vst_decode.sv
module vst_decode
    import vst_pkg::*;
(
    input  logic [31:0] instr,
    output logic        match,
    output logic [4:0]  zt,
    output logic [4:0]  rn,
    output logic [8:0]  imm
);
    always_comb begin
        match = (instr[31:22] == OPC_HI) && (instr[15:13] == OPC_MID);
        zt    = instr[4:0];
        rn    = instr[9:5];
        imm   = {instr[21:16], instr[12:10]};
    end
endmodule

// File: rtl/vst_addr_gen.sv
module vst_addr_gen #(
    parameter int VLBW = 9
) (
    input  logic [63:0]     base,
    input  logic [8:0]      imm,
    input  logic [VLBW-1:0] vl_bytes,
    output logic [63:0]     start_addr,
    output logic            aligned16
);
    logic signed [63:0] imm_ext;
    logic signed [63:0] len_ext;
    logic signed [63:0] offset;

    always_comb begin
        imm_ext    = $signed({{55{imm[8]}}, imm});
        len_ext    = $signed({{(64-VLBW){1'b0}}, vl_bytes});
        offset     = imm_ext * len_ext;
        start_addr = base + offset;
        aligned16  = (base[3:0] == 4'd0);
    end
endmodule

// File: rtl/vst_byte_pick.sv
module vst_byte_pick #(
    parameter int MAX_VL = 2048,
    parameter int IDXW   = 9
) (
    input  logic [MAX_VL-1:0] vec,
    input  logic [IDXW-1:0]   idx,
    output logic [7:0]        byte_o
);
    logic [IDXW+2:0] bit_pos;

    always_comb begin
        bit_pos = {idx, 3'b000};
        byte_o  = vec[bit_pos +: 8];
    end
endmodule

// File: rtl/vst_byte_store.sv
module vst_byte_store
    import vst_pkg::*;
#(
    parameter int MAX_VL = 2048,
    localparam int VLW  = $clog2(MAX_VL) + 1,
    localparam int VLBW = $clog2(MAX_VL / 8) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr,
    input  logic              feat_en,
    input  logic              align_enf,
    input  logic              sp_chk,
    input  logic [VLW-1:0]    vl_bits,
    output logic [4:0]        gpr_idx,
    input  logic [63:0]       gpr_data,
    input  logic [63:0]       sp_val,
    output logic [4:0]        vreg_idx,
    input  logic [MAX_VL-1:0] vreg_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [63:0]       mem_addr,
    output logic [7:0]        mem_data,
    output logic              mem_tagchk,
    output logic              mem_aligned,
    output logic              busy,
    output logic              done,
    output logic              undef,
    output logic              align_fault,
    output logic [63:0]       fault_addr
);
    localparam int IDXW = VLBW;

    vst_ctl_t          ctl_d, ctl_q;
    logic [MAX_VL-1:0] vec_d, vec_q;
    logic [IDXW-1:0]   idx_d, idx_q;
    logic [IDXW-1:0]   nb_d, nb_q;

    logic              dec_match;
    logic [4:0]        dec_zt;
    logic [4:0]        dec_rn;
    logic [8:0]        dec_imm;
    logic              is_sp;
    logic [63:0]       base;
    logic [VLBW-1:0]   vl_bytes;
    logic [63:0]       start_addr;
    logic              aligned16;
    logic              misalign_fault;

    vst_decode u_dec (
        .instr (instr),
        .match (dec_match),
        .zt    (dec_zt),
        .rn    (dec_rn),
        .imm   (dec_imm)
    );

    assign gpr_idx  = dec_rn;
    assign vreg_idx = dec_zt;
    assign is_sp    = (dec_rn == 5'd31);
    assign base     = is_sp ? sp_val : gpr_data;
    assign vl_bytes = vl_bits[VLW-1:3];

    vst_addr_gen #(.VLBW(VLBW)) u_agen (
        .base       (base),
        .imm        (dec_imm),
        .vl_bytes   (vl_bytes),
        .start_addr (start_addr),
        .aligned16  (aligned16)
    );

    vst_byte_pick #(.MAX_VL(MAX_VL), .IDXW(IDXW)) u_pick (
        .vec    (vec_q),
        .idx    (idx_q),
        .byte_o (mem_data)
    );

    assign misalign_fault = !aligned16 && (align_enf || (is_sp && sp_chk));

    always_comb begin
        ctl_d = ctl_q;
        vec_d = vec_q;
        idx_d = idx_q;
        nb_d  = nb_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.undef = 1'b0;
                    ctl_d.flt   = 1'b0;
                    if (!feat_en || !dec_match) begin
                        ctl_d.undef = 1'b1;
                        ctl_d.st    = ST_FIN;
                    end else if (misalign_fault) begin
                        ctl_d.flt   = 1'b1;
                        ctl_d.faddr = start_addr;
                        ctl_d.st    = ST_FIN;
                    end else begin
                        ctl_d.st   = ST_SEND;
                        ctl_d.addr = start_addr;
                        ctl_d.tag  = !is_sp;
                        ctl_d.algn = aligned16;
                        vec_d      = vreg_data;
                        idx_d      = '0;
                        nb_d       = vl_bytes;
                    end
                end
            end
            ST_SEND: begin
                if (mem_ready) begin
                    if (idx_q == nb_q - 1'b1) begin
                        ctl_d.st = ST_FIN;
                    end else begin
                        idx_d      = idx_q + 1'b1;
                        ctl_d.addr = ctl_q.addr + 64'd1;
                    end
                end
            end
            ST_FIN: begin
                ctl_d.st = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, addr: '0, faddr: '0, tag: 1'b0,
                       algn: 1'b0, undef: 1'b0, flt: 1'b0};
            vec_q <= '0;
            idx_q <= '0;
            nb_q  <= '0;
        end else begin
            ctl_q <= ctl_d;
            vec_q <= vec_d;
            idx_q <= idx_d;
            nb_q  <= nb_d;
        end
    end

    assign mem_valid   = (ctl_q.st == ST_SEND);
    assign mem_addr    = ctl_q.addr;
    assign mem_tagchk  = ctl_q.tag;
    assign mem_aligned = ctl_q.algn;
    assign busy        = (ctl_q.st != ST_IDLE);
    assign done        = (ctl_q.st == ST_FIN);
    assign undef       = done && ctl_q.undef;
    assign align_fault = done && ctl_q.flt;
    assign fault_addr  = ctl_q.faddr;

    // R9
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=> (!mem_valid || (mem_addr == $past(mem_addr) + 64'd1)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R1
    no_write_before_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (undef || align_fault)) |-> (!$past(mem_valid) && $past(busy) == 1'b0));

    // R8
    flags_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && $past(mem_valid)) |-> ($stable(mem_tagchk) && $stable(mem_aligned)));
endmodule

// File: tb/vst_byte_store_tb.sv
`timescale 1ns/1ps
module vst_byte_store_tb_top;
    localparam int MAX_VL = 2048;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [31:0]       instr = '0;
    logic              feat_en = 1'b1;
    logic              align_enf = 1'b0;
    logic              sp_chk = 1'b0;
    logic [11:0]       vl_bits = 12'd128;
    logic [4:0]        gpr_idx;
    logic [63:0]       gpr_data;
    logic [63:0]       sp_val = '0;
    logic [4:0]        vreg_idx;
    logic [MAX_VL-1:0] vreg_data;
    logic              mem_valid;
    logic              mem_ready = 1'b0;
    logic [63:0]       mem_addr;
    logic [7:0]        mem_data;
    logic              mem_tagchk;
    logic              mem_aligned;
    logic              busy;
    logic              done;
    logic              undef;
    logic              align_fault;
    logic [63:0]       fault_addr;

    logic [63:0]       gpr_file [32];
    logic [MAX_VL-1:0] vec_file [32];

    logic [63:0] w_addr [512];
    logic [7:0]  w_data [512];
    logic        w_tag  [512];
    logic        w_al   [512];
    int          nw;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    assign gpr_data  = gpr_file[gpr_idx];
    assign vreg_data = vec_file[vreg_idx];

    always #4 clk = ~clk;

    vst_byte_store #(.MAX_VL(MAX_VL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .feat_en(feat_en), .align_enf(align_enf), .sp_chk(sp_chk),
        .vl_bits(vl_bits), .gpr_idx(gpr_idx), .gpr_data(gpr_data),
        .sp_val(sp_val), .vreg_idx(vreg_idx), .vreg_data(vreg_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_tagchk(mem_tagchk), .mem_aligned(mem_aligned),
        .busy(busy), .done(done), .undef(undef), .align_fault(align_fault),
        .fault_addr(fault_addr)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<190000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [4:0] zt, input logic [4:0] rn, input logic [8:0] imm);
        return {10'b1110010110, imm[8:3], 3'b010, imm[2:0], rn, zt};
    endfunction

    function automatic logic [63:0] exp_start(input logic [63:0] b, input logic [8:0] imm, input logic [11:0] vl);
        logic signed [63:0] s;
        s = $signed({{55{imm[8]}}, imm});
        return b + s * $signed({55'd0, vl[11:3]});
    endfunction

    task automatic run_op(input logic [31:0] ins, input bit fe, input bit ae, input bit spc,
                          input logic [11:0] vl, input bit poke);
        logic [4:0]  rn, zt;
        logic [8:0]  imm;
        logic [63:0] b, sa;
        bit          ok_word, exp_fault, mism;
        int          nexp, cyc, bad_i;
        rn = ins[9:5];
        zt = ins[4:0];
        imm = {ins[21:16], ins[12:10]};
        ok_word = (ins[31:22] == 10'b1110010110) && (ins[15:13] == 3'b010) && fe;
        b = (rn == 5'd31) ? sp_val : gpr_file[rn];
        sa = exp_start(b, imm, vl);
        exp_fault = ok_word && (b[3:0] != 4'd0) && (ae || (rn == 5'd31 && spc));
        nexp = (ok_word && !exp_fault) ? int'(vl / 8) : 0;

        @(negedge clk);
        check(!busy, "R10 idle before start", {63'd0, busy}, 64'd0);
        instr = ins; feat_en = fe; align_enf = ae; sp_chk = spc; vl_bits = vl; start = 1'b1;
        #1;
        check(gpr_idx == rn && vreg_idx == zt, "R2 read indices",
              {54'd0, gpr_idx, vreg_idx}, {54'd0, rn, zt});
        @(negedge clk);
        start = 1'b0;
        nw = 0;
        cyc = 0;
        while (!done && cyc < 3000) begin
            if (poke && cyc == 3) begin
                start = 1'b1;
                instr = mk(5'd1, 5'd2, 9'd7);
            end else begin
                start = 1'b0;
                instr = ins;
            end
            mem_ready = ($urandom % 4) != 0;
            if (mem_valid && mem_ready && nw < 512) begin
                w_addr[nw] = mem_addr;
                w_data[nw] = mem_data;
                w_tag[nw]  = mem_tagchk;
                w_al[nw]   = mem_aligned;
                nw = nw + 1;
            end
            @(negedge clk);
            cyc = cyc + 1;
        end
        start = 1'b0;
        mem_ready = 1'b0;
        check(done == 1'b1, "R10 done reached", {63'd0, done}, 64'd1);
        check(undef == !ok_word, "R1 undef flag", {63'd0, undef}, {63'd0, !ok_word});
        check(align_fault == exp_fault, "R6/R7 fault flag", {63'd0, align_fault}, {63'd0, exp_fault});
        if (exp_fault)
            check(fault_addr == sa, "R6 fault address", fault_addr, sa);
        check(nw == nexp, "R5 write count", 64'(nw), 64'(nexp));
        mism = 1'b0;
        bad_i = 0;
        for (int e = 0; e < nw && e < nexp; e++) begin
            if (!mism && (w_addr[e] != sa + 64'(e) || w_data[e] != vec_file[zt][8*e +: 8])) begin
                mism = 1'b1;
                bad_i = e;
            end
        end
        if (nexp > 0) begin
            check(!mism, "R3/R5 byte stream", {w_addr[bad_i][55:0], w_data[bad_i]},
                  {(sa + 64'(bad_i)), 8'd0} >> 0 | {(sa[55:0] + 56'(bad_i)), vec_file[zt][8*bad_i +: 8]});
            check(w_tag[0] == (rn != 5'd31), "R4 tag check flag", {63'd0, w_tag[0]}, {63'd0, rn != 5'd31});
            check(w_al[0] == (b[3:0] == 4'd0), "R8 aligned flag", {63'd0, w_al[0]}, {63'd0, b[3:0] == 4'd0});
        end
        @(negedge clk);
        check(!busy && !done, "R10 idle after done", {62'd0, busy, done}, 64'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int r = 0; r < 32; r++) begin
            gpr_file[r] = {$urandom, $urandom};
            for (int w = 0; w < MAX_VL / 32; w++)
                vec_file[r][32*w +: 32] = $urandom;
        end
        gpr_file[3] = 64'h0000_0000_0001_0000;
        gpr_file[4] = 64'hFFFF_FFFF_FFFF_FFF0;
        gpr_file[5] = 64'h0000_0000_0000_1008;
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_valid, "R10 reset state",
              {61'd0, busy, done, mem_valid}, 64'd0);
        rst_n = 1'b1;

        // R1 wrong opcode, wrong middle bits, feature disabled
        run_op(mk(5'd1, 5'd3, 9'd0) ^ 32'h8000_0000, 1, 0, 0, 12'd128, 0);
        run_op(mk(5'd1, 5'd3, 9'd0) ^ 32'h0000_4000, 1, 0, 0, 12'd128, 0);
        run_op(mk(5'd1, 5'd3, 9'd0), 0, 0, 0, 12'd128, 0);
        // R3 immediate extremes, R5 smallest and largest VL
        run_op(mk(5'd7, 5'd3, 9'h100), 1, 0, 0, 12'd128, 0);
        run_op(mk(5'd8, 5'd3, 9'h0FF), 1, 0, 0, 12'd2048, 1);
        // R3 wrap past 2^64
        run_op(mk(5'd9, 5'd4, 9'd1), 1, 1, 0, 12'd256, 0);
        // R6 enforced misalignment
        run_op(mk(5'd2, 5'd5, 9'd3), 1, 1, 0, 12'd512, 0);
        // R8 misaligned base allowed when not enforced
        run_op(mk(5'd2, 5'd5, 9'h1FF), 1, 0, 0, 12'd384, 0);
        // R7 stack pointer misaligned with only the SP check on
        sp_val = 64'h0000_7FFF_0000_0004;
        run_op(mk(5'd6, 5'd31, 9'd2), 1, 0, 1, 12'd128, 0);
        // R4 stack pointer base, checks off
        run_op(mk(5'd6, 5'd31, 9'd2), 1, 0, 0, 12'd128, 0);
        sp_val = 64'h0000_7FFF_0000_0100;
        run_op(mk(5'd6, 5'd31, 9'h1F0), 1, 1, 1, 12'd640, 1);

        for (int k = 0; k < 40; k++) begin
            logic [4:0] rn_r;
            rn_r = 5'($urandom);
            if ($urandom % 2) gpr_file[rn_r][3:0] = 4'd0;
            if (rn_r == 5'd31) sp_val = {$urandom, $urandom[31:4], 4'($urandom % 2 ? 0 : 8)};
            run_op(mk(5'($urandom), rn_r, 9'($urandom)), ($urandom % 8) != 0,
                   $urandom % 2, $urandom % 2, 12'((1 + $urandom % 16) * 128), $urandom % 2);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule